// File: doc/BRIEF.md
# Quad I/O Fast Read Target Front End

This block is the target-side read path of a serial flash. It watches chip select, the serial clock and four data lines. It decodes a quad input/output fast read: a command byte, a 24-bit address, a mode byte and a fixed run of dummy clocks. It then fetches bytes from a synchronous memory read port and returns them four bits per serial clock, high nibble first. The address steps forward by one for each byte until chip select is released.

The command byte arrives one bit per clock on line 0. When the quad command input is set, it arrives four bits per clock instead. The mode byte decides how the next transaction starts. When its upper nibble is the bitwise inverse of its lower nibble, the next transaction begins directly with the address and carries no command byte. A busy input marks a program or erase operation in progress. While it is high, reads are refused and the data lines stay released.

All pins are sampled in the system clock domain, so each serial clock half period must last at least four system clocks. The data lines appear as separate input, output and output-enable signals, and the pad logic sits outside this block.

Top module: `qrd_flash_read`

## Requirements
- R1: After reset `dq_oe` and `mem_rd_en` are low and continuous mode is off, so the first transaction needs a command byte.
- R2: With `quad_cmd_en` low, the command is shifted in on `dq_in[0]`, MSB first, over 8 rising serial clocks. Only code 0xEB starts a read; any other code leaves the lines released until chip select rises.
- R3: With `quad_cmd_en` high, the command is taken in over 2 rising serial clocks from `dq_in[3:0]`, high nibble first.
- R4: The address follows over 6 rising clocks, most significant nibble first. The first byte returned is the memory content at that address.
- R5: The mode byte takes 2 rising clocks, high nibble first, followed by exactly 4 dummy clocks. The first data nibble is driven on the falling edge after the 4th dummy rising edge. Each byte is sent high nibble, then low nibble, one per falling edge.
- R6: Each further byte comes from the next address, and the address wraps from 0xFFFFFF to 0x000000.
- R7: A mode byte whose bits [7:4] equal the inverse of bits [3:0] (for example 0xA5, 0x5A, 0xF0, 0x0F) makes the next transaction start with the address, with no command byte.
- R8: Any other mode byte (for example 0xFF, 0x00, 0xAA, 0x55) turns continuous mode off when chip select rises, so the next transaction must start with a command byte.
- R9: If `busy` is high at the end of the command phase, or at the end of the address phase, the read is refused, no data is driven, and the continuous-mode state is left unchanged.
- R10: `dq_oe` is high only in the data phase and drops within two system clocks after chip select rises.
- R11: Chip select rising at any point aborts the transaction and resets the phase counters. The next transaction starts from its first phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from the host |
| dq_in | input | 4 | Data lines as seen at the pads |
| quad_cmd_en | input | 1 | Command byte is taken on four lines when high |
| busy | input | 1 | Program, erase or status write in progress |
| dq_out | output | 4 | Data nibble to drive |
| dq_oe | output | 1 | Output enable for all four data lines |
| mem_rd_en | output | 1 | Memory read request, data valid the next cycle |
| mem_addr | output | 24 | Memory read address |
| mem_rdata | input | 8 | Memory read data |

## Verification
A wrong phase counter or shift register shows up within the same transaction. The enable rises one clock early or late, or the first nibble comes from the wrong byte, and either is visible on the first data clock. A wrong prefetch pointer shows up two nibbles later as a repeated or skipped byte. That check includes the wrap at the top of the address space. A wrong continuous-mode flag is invisible until the next chip select cycle, where the bench sees either missing data or data from a misparsed address on its first data clock.

// File: rtl/qrd_pkg.sv
package qrd_pkg;

    localparam int NIB_W = 4;

    typedef enum logic [2:0] {
        PH_CMD,
        PH_ADDR,
        PH_MODE,
        PH_DUMMY,
        PH_DATA,
        PH_IGNORE
    } phase_e;

    typedef struct packed {
        logic             cs_n;
        logic             rise;
        logic             fall;
        logic [NIB_W-1:0] dq;
    } bus_evt_t;

    function automatic logic mode_keeps(input logic [7:0] p);
        return p[7:4] == ~p[3:0];
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/qrd_sampler.sv
module qrd_sampler
    import qrd_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             sck,
    input  logic [NIB_W-1:0] dq_in,
    output bus_evt_t         evt
);

    logic             cs_q;
    logic             sck_q;
    logic             sck_d;
    logic [NIB_W-1:0] dq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cs_q  <= 1'b1;
            sck_q <= 1'b0;
            sck_d <= 1'b0;
            dq_q  <= '0;
        end else begin
            cs_q  <= cs_n;
            sck_q <= sck;
            sck_d <= sck_q;
            dq_q  <= dq_in;
        end
    end

    always_comb begin
        evt.cs_n = cs_q;
        evt.rise = !cs_q && sck_q && !sck_d;
        evt.fall = !cs_q && !sck_q && sck_d;
        evt.dq   = dq_q;
    end

endmodule

// File: rtl/qrd_sequencer.sv
module qrd_sequencer
    import qrd_pkg::*;
#(
    parameter int          ADDR_W       = 24,
    parameter int          DUMMY_CYCLES = 4,
    parameter logic [7:0]  CMD_CODE     = 8'hEB
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_hi,
    input  logic              rise,
    input  logic [NIB_W-1:0]  dq,
    input  logic              quad_cmd_en,
    input  logic              busy,
    output phase_e            phase,
    output logic              fetch_go,
    output logic [ADDR_W-1:0] fetch_addr
);

    localparam int ADDR_NIBS = ADDR_W / NIB_W;
    localparam int CNT_MAX   = max3(8, ADDR_NIBS, DUMMY_CYCLES);
    localparam int CNT_W     = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] ADDR_LAST  = CNT_W'(ADDR_NIBS - 1);
    localparam logic [CNT_W-1:0] DUMMY_LAST = CNT_W'(DUMMY_CYCLES - 1);
    localparam logic [CNT_W-1:0] MODE_LAST  = CNT_W'(1);

    logic [CNT_W-1:0]  cnt;
    logic [7:0]        cmd_sh;
    logic [7:0]        cmd_nx;
    logic [ADDR_W-1:0] addr_sh;
    logic [ADDR_W-1:0] addr_nx;
    logic [7:0]        mode_sh;
    logic [7:0]        mode_nx;
    logic [CNT_W-1:0]  cmd_last;
    logic              cont_q;
    logic              pend_v;
    logic              pend_keep;

    always_comb begin
        cmd_nx   = quad_cmd_en ? {cmd_sh[3:0], dq} : {cmd_sh[6:0], dq[0]};
        cmd_last = quad_cmd_en ? CNT_W'(1) : CNT_W'(7);
        addr_nx  = {addr_sh[ADDR_W-NIB_W-1:0], dq};
        mode_nx  = {mode_sh[3:0], dq};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase     <= PH_CMD;
            cnt       <= '0;
            cmd_sh    <= '0;
            addr_sh   <= '0;
            mode_sh   <= '0;
            cont_q    <= 1'b0;
            pend_v    <= 1'b0;
            pend_keep <= 1'b0;
            fetch_go  <= 1'b0;
        end else begin
            fetch_go <= 1'b0;
            if (cs_hi) begin
                cnt <= '0;
                if (pend_v) begin
                    cont_q <= pend_keep;
                    pend_v <= 1'b0;
                    phase  <= pend_keep ? PH_ADDR : PH_CMD;
                end else begin
                    phase  <= cont_q ? PH_ADDR : PH_CMD;
                end
            end else if (rise) begin
                unique case (phase)
                    PH_CMD: begin
                        cmd_sh <= cmd_nx;
                        if (cnt == cmd_last) begin
                            cnt   <= '0;
                            phase <= (cmd_nx == CMD_CODE && !busy) ? PH_ADDR : PH_IGNORE;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_ADDR: begin
                        addr_sh <= addr_nx;
                        if (cnt == ADDR_LAST) begin
                            cnt <= '0;
                            if (busy) begin
                                phase <= PH_IGNORE;
                            end else begin
                                phase    <= PH_MODE;
                                fetch_go <= 1'b1;
                            end
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_MODE: begin
                        mode_sh <= mode_nx;
                        if (cnt == MODE_LAST) begin
                            cnt       <= '0;
                            pend_v    <= 1'b1;
                            pend_keep <= mode_keeps(mode_nx);
                            phase     <= PH_DUMMY;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    PH_DUMMY: begin
                        if (cnt == DUMMY_LAST) begin
                            cnt   <= '0;
                            phase <= PH_DATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                    default: begin
                        cnt <= cnt;
                    end
                endcase
            end
        end
    end

    assign fetch_addr = addr_sh;

    // R7 R8: the continuous flag only moves while chip select is high
    p_cont_steady_r7: assert property (@(posedge clk) disable iff (rst)
        (!cs_hi && $past(!cs_hi)) |-> $stable(cont_q));

    // R4: a fetch is launched exactly as the mode phase begins
    p_fetch_at_mode_r4: assert property (@(posedge clk) disable iff (rst)
        fetch_go |-> (phase == PH_MODE));

    // R5: the data phase is entered only from the dummy phase
    p_data_after_dummy_r5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_DATA && $past(phase) != PH_DATA) |-> ($past(phase) == PH_DUMMY));

    // R9: a refused read stays refused until chip select rises
    p_ignore_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IGNORE && !cs_hi) |=> (phase == PH_IGNORE));

endmodule

// File: rtl/qrd_stream.sv
module qrd_stream
    import qrd_pkg::*;
#(
    parameter int ADDR_W = 24
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_hi,
    input  logic              fall,
    input  phase_e            phase,
    input  logic              fetch_go,
    input  logic [ADDR_W-1:0] fetch_addr,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    output logic [NIB_W-1:0]  dq_out,
    output logic              dq_oe
);

    localparam logic [ADDR_W-1:0] ADDR_ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] ptr;
    logic              rd_wait;
    logic [7:0]        next_byte;
    logic [7:0]        cur_byte;
    logic              nib_lo;

    always_ff @(posedge clk) begin
        if (rst) begin
            mem_rd_en <= 1'b0;
            mem_addr  <= '0;
            ptr       <= '0;
            rd_wait   <= 1'b0;
            next_byte <= '0;
            cur_byte  <= '0;
            nib_lo    <= 1'b0;
            dq_out    <= '0;
            dq_oe     <= 1'b0;
        end else begin
            mem_rd_en <= 1'b0;
            rd_wait   <= mem_rd_en;
            if (rd_wait) begin
                next_byte <= mem_rdata;
            end
            if (cs_hi) begin
                dq_oe  <= 1'b0;
                dq_out <= '0;
                nib_lo <= 1'b0;
            end else if (fetch_go) begin
                mem_rd_en <= 1'b1;
                mem_addr  <= fetch_addr;
                ptr       <= fetch_addr + ADDR_ONE;
                nib_lo    <= 1'b0;
            end else if (fall && phase == PH_DATA) begin
                dq_oe <= 1'b1;
                if (!nib_lo) begin
                    dq_out    <= next_byte[7:4];
                    cur_byte  <= next_byte;
                    mem_rd_en <= 1'b1;
                    mem_addr  <= ptr;
                    ptr       <= ptr + ADDR_ONE;
                    nib_lo    <= 1'b1;
                end else begin
                    dq_out <= cur_byte[3:0];
                    nib_lo <= 1'b0;
                end
            end
        end
    end

    // R10: lines are driven only while the sequencer is in its data phase
    p_oe_data_only_r10: assert property (@(posedge clk) disable iff (rst)
        dq_oe |-> (phase == PH_DATA));

    // R10: chip select high releases the lines on the next clock
    p_release_r10: assert property (@(posedge clk) disable iff (rst)
        cs_hi |=> !dq_oe);

    // R9: no memory request while a refused transaction is in progress
    p_no_read_ignored_r9: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_IGNORE && $past(phase) == PH_IGNORE) |-> !mem_rd_en);

endmodule

// File: rtl/qrd_flash_read.sv
module qrd_flash_read
    import qrd_pkg::*;
#(
    parameter int         ADDR_W       = 24,
    parameter int         DUMMY_CYCLES = 4,
    parameter logic [7:0] CMD_CODE     = 8'hEB
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sck,
    input  logic [3:0]        dq_in,
    input  logic              quad_cmd_en,
    input  logic              busy,
    output logic [3:0]        dq_out,
    output logic              dq_oe,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata
);

    bus_evt_t          evt;
    phase_e            phase;
    logic              fetch_go;
    logic [ADDR_W-1:0] fetch_addr;

    qrd_sampler i_sampler (
        .clk   (clk),
        .rst   (rst),
        .cs_n  (cs_n),
        .sck   (sck),
        .dq_in (dq_in),
        .evt   (evt)
    );

    qrd_sequencer #(
        .ADDR_W       (ADDR_W),
        .DUMMY_CYCLES (DUMMY_CYCLES),
        .CMD_CODE     (CMD_CODE)
    ) i_sequencer (
        .clk         (clk),
        .rst         (rst),
        .cs_hi       (evt.cs_n),
        .rise        (evt.rise),
        .dq          (evt.dq),
        .quad_cmd_en (quad_cmd_en),
        .busy        (busy),
        .phase       (phase),
        .fetch_go    (fetch_go),
        .fetch_addr  (fetch_addr)
    );

    qrd_stream #(
        .ADDR_W (ADDR_W)
    ) i_stream (
        .clk        (clk),
        .rst        (rst),
        .cs_hi      (evt.cs_n),
        .fall       (evt.fall),
        .phase      (phase),
        .fetch_go   (fetch_go),
        .fetch_addr (fetch_addr),
        .mem_rd_en  (mem_rd_en),
        .mem_addr   (mem_addr),
        .mem_rdata  (mem_rdata),
        .dq_out     (dq_out),
        .dq_oe      (dq_oe)
    );

    // R1: nothing is driven or requested in the cycle after reset
    p_reset_quiet_r1: assert property (@(posedge clk)
        $past(rst) |-> (!dq_oe && !mem_rd_en));

endmodule

// File: tb/test_qrd_flash_read.sv
module test_qrd_flash_read;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        sck = 1'b0;
    logic [3:0]  dq_in = '0;
    logic        quad_cmd_en = 1'b0;
    logic        busy = 1'b0;
    logic [3:0]  dq_out;
    logic        dq_oe;
    logic        mem_rd_en;
    logic [23:0] mem_addr;
    logic [7:0]  mem_rdata = '0;

    int n_checks = 0;
    int n_err    = 0;
    bit done     = 1'b0;
    bit cont_m   = 1'b0;

    always #2.5 clk = ~clk;

    qrd_flash_read i_qrd_flash_read (
        .clk         (clk),
        .rst         (rst),
        .cs_n        (cs_n),
        .sck         (sck),
        .dq_in       (dq_in),
        .quad_cmd_en (quad_cmd_en),
        .busy        (busy),
        .dq_out      (dq_out),
        .dq_oe       (dq_oe),
        .mem_rd_en   (mem_rd_en),
        .mem_addr    (mem_addr),
        .mem_rdata   (mem_rdata)
    );

    function automatic logic [7:0] mem_byte(input logic [23:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ a[23:16] ^ 8'h96;
    endfunction

    always_ff @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem_byte(mem_addr);
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic sclk(input logic [3:0] d, output logic [3:0] o, output logic e);
        dq_in = d;
        repeat (4) @(negedge clk);
        o = dq_out;
        e = dq_oe;
        sck = 1'b1;
        repeat (4) @(negedge clk);
        sck = 1'b0;
    endtask

    // Reference model: one entry per serial clock, compared every clock.
    task automatic xact(input bit send_cmd, input logic [7:0] cmd,
                        input logic [23:0] a, input logic [7:0] m,
                        input int nbytes, input int stop_at, input string req);
        logic [3:0] q[$];
        logic [3:0] o;
        logic       e;
        int         first;
        bit         ok_exp;
        ok_exp = !busy && (cont_m ? !send_cmd : (send_cmd && cmd == 8'hEB))
                 && (stop_at < 0);
        if (send_cmd) begin
            if (quad_cmd_en) begin
                q.push_back(cmd[7:4]);
                q.push_back(cmd[3:0]);
            end else begin
                for (int i = 7; i >= 0; i--) q.push_back({3'b000, cmd[i]});
            end
        end
        for (int i = 5; i >= 0; i--) q.push_back(a[4*i +: 4]);
        q.push_back(m[7:4]);
        q.push_back(m[3:0]);
        repeat (4) q.push_back(4'h0);
        first = q.size();
        repeat (nbytes * 2) q.push_back(4'h0);
        cs_n = 1'b0;
        repeat (4) @(negedge clk);
        for (int i = 0; i < q.size(); i++) begin
            if (stop_at >= 0 && i == stop_at) break;
            sclk(q[i], o, e);
            if (ok_exp && i >= first) begin
                int         j;
                logic [7:0] b;
                logic [3:0] en;
                j  = i - first;
                b  = mem_byte(a + 24'(j / 2));
                en = (j % 2 == 0) ? b[7:4] : b[3:0];
                check(e == 1'b1 && o == en, req, "data nibble", {e, o}, {1'b1, en});
            end else begin
                check(e == 1'b0, req, "lines released", e, 0);
            end
        end
        repeat (2) @(negedge clk);
        cs_n = 1'b1;
        repeat (2) @(negedge clk);
        check(dq_oe == 1'b0, "R10", "release after cs high", dq_oe, 0);
        repeat (6) @(negedge clk);
        if (ok_exp) cont_m = (m[7:4] == ~m[3:0]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_err++;
            $display("FAIL R10 watchdog expired: actual 1 expected 0");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        // R1: quiet after reset
        check(dq_oe == 1'b0, "R1", "dq_oe after reset", dq_oe, 0);
        check(mem_rd_en == 1'b0, "R1", "mem_rd_en after reset", mem_rd_en, 0);

        // R2 R4 R5: serial command, plain mode byte
        xact(1'b1, 8'hEB, 24'h012345, 8'h00, 3, -1, "R2/R4/R5 serial read");
        // R2: wrong command code is refused
        xact(1'b1, 8'h0B, 24'h000040, 8'h00, 2, -1, "R2 wrong code");
        // R3 R7: quad command, enter continuous mode
        quad_cmd_en = 1'b1;
        xact(1'b1, 8'hEB, 24'hABCDE0, 8'hA5, 2, -1, "R3/R7 quad command");
        // R7: address-first transaction
        xact(1'b0, 8'h00, 24'h000100, 8'h5A, 2, -1, "R7 continuous");
        // R6: wrap at top of address space
        xact(1'b0, 8'h00, 24'hFFFFFF, 8'hF0, 3, -1, "R6 wrap");
        // R9: busy refuses a continuous read, flag unchanged
        busy = 1'b1;
        xact(1'b0, 8'h00, 24'h222222, 8'h00, 2, -1, "R9 busy continuous");
        busy = 1'b0;
        // R8: leave continuous mode with 0xFF
        xact(1'b0, 8'h00, 24'h000010, 8'hFF, 1, -1, "R8 leave");
        // R8: command is needed again
        quad_cmd_en = 1'b0;
        xact(1'b1, 8'hEB, 24'h300000, 8'h0F, 2, -1, "R8 command again");
        // R11: abort mid-address, then a full continuous read works
        xact(1'b0, 8'h00, 24'h777777, 8'hA5, 2, 3, "R11 abort");
        xact(1'b0, 8'h00, 24'h000020, 8'h55, 1, -1, "R11 restart");
        // R9: busy refuses the command in normal mode
        busy = 1'b1;
        xact(1'b1, 8'hEB, 24'h000030, 8'hA5, 2, -1, "R9 busy command");
        busy = 1'b0;
        xact(1'b1, 8'hEB, 24'h0000F0, 8'hAA, 2, -1, "R9 after busy");
        // R8: address-first without continuous mode gives no data
        xact(1'b0, 8'h00, 24'h000000, 8'h00, 2, -1, "R8 no continuous");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule